// File: doc/BRIEF.md
# Translation Request and Miss Controller

This block sits between an upstream translation requester and a translation array. It owns a small pool of in-flight slots, each holding one page number and the progress of that translation. A request is admitted only while a slot is free. The array is probed in the same cycle as admission, and the result is acted on after a fixed hit delay. A hit goes straight to the response stage. A miss goes either to a lower translation level, over a valid/ready port, or to a page-walk port after a second fixed delay. The `lower_en` strap picks which of the two.

Translations returned from below are latched for one clock and then matched to their waiting slot. When the allocate policy input is set, each returned translation is also offered to the array for filling. Responses carry:

- the physical address;
- a permission fault flag;
- a fault class derived from the access kind;
- an uncacheable flag.

Each response retires its slot in the same edge. One cycle later, every upstream port receives a retry pulse.

Top module: `tlb_miss_ctrl`

## Requirements
- R1: `req_ready` is high exactly when fewer than MAX_OUT translations are in flight. The count rises on each accepted request and falls on the edge that emits a response. `refused_cnt` increments once for every cycle in which `req_valid` is high while `req_ready` is low.
- R2: No two in-flight translations may share a page number (address bits above PAGE_SHIFT). Distinct pages may all be in flight at once.
- R3: A request that hits in the array (`lk_hit`=1 in its accepting cycle) produces `rsp_valid` HIT_LAT+1 clock edges after the accepting edge.
- R4: With `lower_en`=1, a miss raises `dn_valid` with its page on `dn_vpn` HIT_LAT+1 edges after acceptance, provided the port is idle. `dn_valid` and `dn_vpn` are held unchanged until `dn_ready` is seen high.
- R5: With `lower_en`=0, a miss produces a one-cycle `walk_valid` carrying its page on `walk_vpn`, HIT_LAT+MISS_LAT edges after acceptance.
- R6: A translation presented on `ret_valid` at one edge produces its response two edges later. It is matched to its waiting request by page number.
- R7: `alloc_valid` pulses one edge after a returned translation, with that page and frame, only when `alloc_en` is 1. With `alloc_en`=0 no fill is offered.
- R8: Access kinds are encoded on `req_mode` as 0 = read, 1 = write, 2 = execute. `rsp_code` is 0 (load-page) for reads, 1 (store-page) for writes and 2 (instruction-page) for execute. `rsp_fault` is 1 only for a write to a page whose writable bit is 0.
- R9: `rsp_uc` equals the uncacheable attribute of the translation used: from the array on a hit, from the return port on a miss.
- R10: `rsp_paddr` is the frame number concatenated above the request's low PAGE_SHIFT address bits.
- R11: Every bit of `retry` is high for exactly the one cycle after each cycle with `rsp_valid` high.
- R12: After reset `req_ready`=1, `refused_cnt`=0, and `rsp_valid`, `dn_valid`, `walk_valid`, `alloc_valid` and `retry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lower_en | input | 1 | Static strap: 1 sends misses to a lower level, 0 to the page walker |
| alloc_en | input | 1 | Allocate-on-miss policy |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | A slot is available |
| req_vaddr | input | VA_W | Request virtual address |
| req_mode | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| lk_vpn | output | VA_W-PAGE_SHIFT | Page number probed in the array |
| lk_hit | input | 1 | Array hit for `lk_vpn` |
| lk_ppn | input | PPN_W | Frame number from the array |
| lk_wr | input | 1 | Writable attribute from the array |
| lk_uc | input | 1 | Uncacheable attribute from the array |
| dn_valid | output | 1 | Miss forwarded to the lower level |
| dn_ready | input | 1 | Lower level accepts the miss |
| dn_vpn | output | VA_W-PAGE_SHIFT | Page number of the forwarded miss |
| walk_valid | output | 1 | Page-walk start pulse |
| walk_vpn | output | VA_W-PAGE_SHIFT | Page number to walk |
| ret_valid | input | 1 | Translation returned from below |
| ret_vpn | input | VA_W-PAGE_SHIFT | Page number of the returned translation |
| ret_ppn | input | PPN_W | Returned frame number |
| ret_wr | input | 1 | Returned writable attribute |
| ret_uc | input | 1 | Returned uncacheable attribute |
| alloc_valid | output | 1 | Fill request to the array |
| alloc_vpn | output | VA_W-PAGE_SHIFT | Fill page number |
| alloc_ppn | output | PPN_W | Fill frame number |
| alloc_wr | output | 1 | Fill writable attribute |
| alloc_uc | output | 1 | Fill uncacheable attribute |
| rsp_valid | output | 1 | Translation response |
| rsp_paddr | output | PPN_W+PAGE_SHIFT | Physical address |
| rsp_fault | output | 1 | Write-permission fault |
| rsp_code | output | 2 | Fault class |
| rsp_uc | output | 1 | Uncacheable flag |
| retry | output | NUM_UP | Retry pulse to each upstream port |
| refused_cnt | output | REF_W | Count of refused request cycles |

## Verification
The assertions assume three things about the inputs:

- The requester never has two translations for the same page in flight.
- `lower_en` changes only while no slot is busy.
- Each return arrives for a page that is actually waiting.

The stimulus keeps to these assumptions as follows:

- Every admitted page number is distinct while it is outstanding.
- The strap is changed only after everything has drained, with an idle cycle before the next request.
- A return is sent only after the bench has seen the corresponding walk pulse or downstream handshake.

Returns and hit traffic are also kept apart in time, so that at most one slot reaches the response stage on any edge.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

  typedef logic [1:0] acc_mode_t;

  localparam acc_mode_t MODE_RD = 2'd0;
  localparam acc_mode_t MODE_WR = 2'd1;

  localparam logic [1:0] FC_LOAD  = 2'd0;
  localparam logic [1:0] FC_STORE = 2'd1;
  localparam logic [1:0] FC_INST  = 2'd2;

  typedef enum logic [2:0] {
    SL_FREE,
    SL_LOOKUP,
    SL_SEND_DN,
    SL_WALK_DLY,
    SL_AWAIT,
    SL_RESP
  } slot_st_t;

endpackage

// File: rtl/tlbc_pick.sv
module tlbc_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlbc_slot.sv
module tlbc_slot
  import tlbc_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int OFF_W    = 12,
  parameter int PPN_W    = 20,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 4,
  parameter int TMR_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [VPN_W-1:0] take_vpn,
  input  logic [OFF_W-1:0] take_off,
  input  acc_mode_t        take_mode,
  input  logic             take_hit,
  input  logic [PPN_W-1:0] take_ppn,
  input  logic             take_wr,
  input  logic             take_uc,
  input  logic             lower_en,
  input  logic             dn_sent,
  input  logic             ret_v,
  input  logic [VPN_W-1:0] ret_vpn,
  input  logic [PPN_W-1:0] ret_ppn,
  input  logic             ret_wr,
  input  logic             ret_uc,
  input  logic             done,
  output slot_st_t         st,
  output logic [VPN_W-1:0] vpn,
  output logic [OFF_W-1:0] off,
  output acc_mode_t        mode,
  output logic [PPN_W-1:0] ppn,
  output logic             wr,
  output logic             uc,
  output logic             walk_fire,
  output logic             ret_hit
);
  logic [TMR_W-1:0] tmr;
  logic             hit_q;

  assign walk_fire = (st == SL_WALK_DLY) && (tmr == TMR_W'(1));
  assign ret_hit   = (st == SL_AWAIT) && ret_v && (ret_vpn == vpn);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SL_FREE;
      tmr   <= '0;
      hit_q <= 1'b0;
      vpn   <= '0;
      off   <= '0;
      mode  <= MODE_RD;
      ppn   <= '0;
      wr    <= 1'b0;
      uc    <= 1'b0;
    end else begin
      case (st)
        SL_FREE: if (take) begin
          st    <= SL_LOOKUP;
          tmr   <= TMR_W'(HIT_LAT);
          vpn   <= take_vpn;
          off   <= take_off;
          mode  <= take_mode;
          hit_q <= take_hit;
          ppn   <= take_ppn;
          wr    <= take_wr;
          uc    <= take_uc;
        end
        SL_LOOKUP: begin
          if (tmr == TMR_W'(1)) begin
            if (hit_q)         st <= SL_RESP;
            else if (lower_en) st <= SL_SEND_DN;
            else begin
              st  <= SL_WALK_DLY;
              tmr <= TMR_W'(MISS_LAT);
            end
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        SL_SEND_DN: if (dn_sent) st <= SL_AWAIT;
        SL_WALK_DLY: begin
          if (tmr == TMR_W'(1)) st <= SL_AWAIT;
          else                  tmr <= tmr - TMR_W'(1);
        end
        SL_AWAIT: if (ret_hit) begin
          st  <= SL_RESP;
          ppn <= ret_ppn;
          wr  <= ret_wr;
          uc  <= ret_uc;
        end
        SL_RESP: if (done) st <= SL_FREE;
        default: st <= SL_FREE;
      endcase
    end
  end

  // R1
  take_free_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> st == SL_FREE);
  // R6
  ret_to_resp_chk: assert property (@(posedge clk) disable iff (rst)
    ret_hit |=> st == SL_RESP);
  // R11
  done_resp_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> st == SL_RESP);
  // R4
  dn_from_send_chk: assert property (@(posedge clk) disable iff (rst)
    dn_sent |-> st == SL_SEND_DN);
endmodule

// File: rtl/tlb_miss_ctrl.sv
module tlb_miss_ctrl
  import tlbc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PPN_W      = 20,
  parameter int MAX_OUT    = 4,
  parameter int HIT_LAT    = 2,
  parameter int MISS_LAT   = 4,
  parameter int NUM_UP     = 2,
  parameter int REF_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lower_en,
  input  logic                        alloc_en,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [VA_W-1:0]             req_vaddr,
  input  logic [1:0]                  req_mode,
  output logic [VA_W-PAGE_SHIFT-1:0]  lk_vpn,
  input  logic                        lk_hit,
  input  logic [PPN_W-1:0]            lk_ppn,
  input  logic                        lk_wr,
  input  logic                        lk_uc,
  output logic                        dn_valid,
  input  logic                        dn_ready,
  output logic [VA_W-PAGE_SHIFT-1:0]  dn_vpn,
  output logic                        walk_valid,
  output logic [VA_W-PAGE_SHIFT-1:0]  walk_vpn,
  input  logic                        ret_valid,
  input  logic [VA_W-PAGE_SHIFT-1:0]  ret_vpn,
  input  logic [PPN_W-1:0]            ret_ppn,
  input  logic                        ret_wr,
  input  logic                        ret_uc,
  output logic                        alloc_valid,
  output logic [VA_W-PAGE_SHIFT-1:0]  alloc_vpn,
  output logic [PPN_W-1:0]            alloc_ppn,
  output logic                        alloc_wr,
  output logic                        alloc_uc,
  output logic                        rsp_valid,
  output logic [PPN_W+PAGE_SHIFT-1:0] rsp_paddr,
  output logic                        rsp_fault,
  output logic [1:0]                  rsp_code,
  output logic                        rsp_uc,
  output logic [NUM_UP-1:0]           retry,
  output logic [REF_W-1:0]            refused_cnt
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int OFF_W = PAGE_SHIFT;
  localparam int IW    = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam int LAT_M = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
  localparam int TMR_W = $clog2(LAT_M + 1);

  slot_st_t         s_st   [MAX_OUT];
  logic [VPN_W-1:0] s_vpn  [MAX_OUT];
  logic [OFF_W-1:0] s_off  [MAX_OUT];
  acc_mode_t        s_mode [MAX_OUT];
  logic [PPN_W-1:0] s_ppn  [MAX_OUT];
  logic             s_wr   [MAX_OUT];
  logic             s_uc   [MAX_OUT];

  logic [MAX_OUT-1:0] free_v, send_v, resp_v, walk_v, rhit_v, busy_v, same_pg;
  logic [MAX_OUT-1:0] take_v, done_v, dn_sent_v;
  logic [IW-1:0]      free_i, send_i, resp_i, walk_i;
  logic               free_any, send_any, resp_any, walk_any;

  logic [CNT_W-1:0] out_cnt;
  logic             accept;
  logic [IW-1:0]    dn_slot;

  logic             rq_v, rq_wr, rq_uc;
  logic [VPN_W-1:0] rq_vpn;
  logic [PPN_W-1:0] rq_ppn;

  assign lk_vpn    = req_vaddr[VA_W-1:PAGE_SHIFT];
  assign req_ready = out_cnt < CNT_W'(MAX_OUT);
  assign accept    = req_valid && req_ready;

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_slot
    assign free_v[g]    = s_st[g] == SL_FREE;
    assign send_v[g]    = s_st[g] == SL_SEND_DN;
    assign resp_v[g]    = s_st[g] == SL_RESP;
    assign busy_v[g]    = !free_v[g];
    assign same_pg[g]   = busy_v[g] && (s_vpn[g] == lk_vpn);
    assign take_v[g]    = accept && free_any && (free_i == IW'(g));
    assign done_v[g]    = resp_any && (resp_i == IW'(g));
    assign dn_sent_v[g] = dn_valid && dn_ready && (dn_slot == IW'(g));

    tlbc_slot #(
      .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
      .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT), .TMR_W(TMR_W)
    ) u_slot (
      .clk(clk), .rst(rst),
      .take(take_v[g]), .take_vpn(lk_vpn), .take_off(req_vaddr[OFF_W-1:0]),
      .take_mode(req_mode), .take_hit(lk_hit), .take_ppn(lk_ppn),
      .take_wr(lk_wr), .take_uc(lk_uc),
      .lower_en(lower_en), .dn_sent(dn_sent_v[g]),
      .ret_v(rq_v), .ret_vpn(rq_vpn), .ret_ppn(rq_ppn),
      .ret_wr(rq_wr), .ret_uc(rq_uc),
      .done(done_v[g]),
      .st(s_st[g]), .vpn(s_vpn[g]), .off(s_off[g]), .mode(s_mode[g]),
      .ppn(s_ppn[g]), .wr(s_wr[g]), .uc(s_uc[g]),
      .walk_fire(walk_v[g]), .ret_hit(rhit_v[g])
    );
  end

  tlbc_pick #(.N(MAX_OUT), .IW(IW)) u_pick_free (.req(free_v), .any(free_any), .idx(free_i));
  tlbc_pick #(.N(MAX_OUT), .IW(IW)) u_pick_send (.req(send_v), .any(send_any), .idx(send_i));
  tlbc_pick #(.N(MAX_OUT), .IW(IW)) u_pick_resp (.req(resp_v), .any(resp_any), .idx(resp_i));
  tlbc_pick #(.N(MAX_OUT), .IW(IW)) u_pick_walk (.req(walk_v), .any(walk_any), .idx(walk_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt     <= '0;
      refused_cnt <= '0;
      dn_valid    <= 1'b0;
      dn_vpn      <= '0;
      dn_slot     <= '0;
      walk_valid  <= 1'b0;
      walk_vpn    <= '0;
      rq_v        <= 1'b0;
      rq_vpn      <= '0;
      rq_ppn      <= '0;
      rq_wr       <= 1'b0;
      rq_uc       <= 1'b0;
      alloc_valid <= 1'b0;
      alloc_vpn   <= '0;
      alloc_ppn   <= '0;
      alloc_wr    <= 1'b0;
      alloc_uc    <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= 1'b0;
      rsp_code    <= FC_LOAD;
      rsp_uc      <= 1'b0;
      retry       <= '0;
    end else begin
      out_cnt <= out_cnt + CNT_W'(accept) - CNT_W'(resp_any);
      if (req_valid && !req_ready) refused_cnt <= refused_cnt + REF_W'(1);

      if (dn_valid && dn_ready) begin
        dn_valid <= 1'b0;
      end else if (!dn_valid && send_any) begin
        dn_valid <= 1'b1;
        dn_slot  <= send_i;
        dn_vpn   <= s_vpn[send_i];
      end

      walk_valid <= walk_any;
      if (walk_any) walk_vpn <= s_vpn[walk_i];

      rq_v   <= ret_valid;
      rq_vpn <= ret_vpn;
      rq_ppn <= ret_ppn;
      rq_wr  <= ret_wr;
      rq_uc  <= ret_uc;

      alloc_valid <= alloc_en && (|rhit_v);
      alloc_vpn   <= rq_vpn;
      alloc_ppn   <= rq_ppn;
      alloc_wr    <= rq_wr;
      alloc_uc    <= rq_uc;

      rsp_valid <= resp_any;
      if (resp_any) begin
        rsp_paddr <= {s_ppn[resp_i], s_off[resp_i]};
        rsp_fault <= (s_mode[resp_i] == MODE_WR) && !s_wr[resp_i];
        rsp_uc    <= s_uc[resp_i];
        case (s_mode[resp_i])
          MODE_RD: rsp_code <= FC_LOAD;
          MODE_WR: rsp_code <= FC_STORE;
          default: rsp_code <= FC_INST;
        endcase
      end

      retry <= {NUM_UP{rsp_valid}};
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= CNT_W'(MAX_OUT));
  // R1
  cnt_track_chk: assert property (@(posedge clk) disable iff (rst)
    CNT_W'($countones(busy_v)) == out_cnt);
  // R2
  dup_page_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> !(|same_pg));
  // R4
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_vpn));
  // R4
  lower_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (|busy_v) |-> $stable(lower_en));
  // R11
  retry_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> retry == {NUM_UP{1'b1}});
  // R11
  retry_cause_chk: assert property (@(posedge clk) disable iff (rst)
    retry[0] |-> $past(rsp_valid));
  // R8
  fault_kind_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_code == FC_STORE);
endmodule

// File: tb/tlb_miss_ctrl_tb_top.sv
`timescale 1ns/1ps
module tlb_miss_ctrl_tb_top;
  localparam int VA_W = 32, PS = 12, PPN_W = 20, MAXO = 4;
  localparam int H = 2, M = 4, NUP = 2, REF_W = 16;
  localparam int VW = VA_W - PS;

  logic clk = 1'b0, rst = 1'b1;
  logic lower_en = 1'b0, alloc_en = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_mode = '0;
  logic [VW-1:0] lk_vpn;
  logic lk_hit, lk_wr, lk_uc;
  logic [PPN_W-1:0] lk_ppn;
  logic dn_valid, dn_ready = 1'b0;
  logic [VW-1:0] dn_vpn, walk_vpn, alloc_vpn;
  logic walk_valid;
  logic ret_valid = 1'b0, ret_wr = 1'b0, ret_uc = 1'b0;
  logic [VW-1:0] ret_vpn = '0;
  logic [PPN_W-1:0] ret_ppn = '0, alloc_ppn;
  logic alloc_valid, alloc_wr, alloc_uc;
  logic rsp_valid, rsp_fault, rsp_uc;
  logic [PPN_W+PS-1:0] rsp_paddr;
  logic [1:0] rsp_code;
  logic [NUP-1:0] retry;
  logic [REF_W-1:0] refused_cnt;

  always #2.5 clk = ~clk;

  tlb_miss_ctrl #(.VA_W(VA_W), .PAGE_SHIFT(PS), .PPN_W(PPN_W), .MAX_OUT(MAXO),
    .HIT_LAT(H), .MISS_LAT(M), .NUM_UP(NUP), .REF_W(REF_W)) dut_i (
    .clk(clk), .rst(rst), .lower_en(lower_en), .alloc_en(alloc_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_mode(req_mode),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_wr(lk_wr), .lk_uc(lk_uc),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_vpn(dn_vpn),
    .walk_valid(walk_valid), .walk_vpn(walk_vpn),
    .ret_valid(ret_valid), .ret_vpn(ret_vpn), .ret_ppn(ret_ppn), .ret_wr(ret_wr), .ret_uc(ret_uc),
    .alloc_valid(alloc_valid), .alloc_vpn(alloc_vpn), .alloc_ppn(alloc_ppn),
    .alloc_wr(alloc_wr), .alloc_uc(alloc_uc),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_uc(rsp_uc), .retry(retry), .refused_cnt(refused_cnt));

  // array stub: page numbers divisible by 3 miss
  function automatic logic f_hit(logic [VW-1:0] v); return (v % 3) != 0; endfunction
  function automatic logic [PPN_W-1:0] f_ppn(logic [VW-1:0] v); return v[PPN_W-1:0] ^ 20'h5A5A5; endfunction
  always_comb begin
    lk_hit = f_hit(lk_vpn);
    lk_ppn = f_ppn(lk_vpn);
    lk_wr  = lk_vpn[1];
    lk_uc  = lk_vpn[2];
  end

  int n_chk = 0, n_bad = 0, cyc = 0, m_cnt = 0, m_ref = 0;
  bit finished = 0, m_acc = 0, m_dn_v = 0;
  logic [VW-1:0] m_dn_vpn;
  logic [VW-1:0] dq_v[$];
  int dq_e[$];
  logic [1:0] m_mode [int];
  logic [PS-1:0] m_off [int];
  logic [PPN_W+PS-1:0] x_pa [int];
  logic x_f [int], x_u [int], x_r [int];
  logic [1:0] x_c [int];
  logic [VW-1:0] x_walk [int];
  logic [VW+PPN_W-1:0] x_al [int];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic put_rsp(int t, logic [PPN_W-1:0] p, logic w, logic u, logic [1:0] md, logic [PS-1:0] o);
    x_pa[t] = {p, o};
    x_f[t]  = (md == 2'd1) && !w;
    x_c[t]  = (md == 2'd0) ? 2'd0 : (md == 2'd1) ? 2'd1 : 2'd2;
    x_u[t]  = u;
  endtask

  task automatic compare();
    bit er = x_pa.exists(cyc);
    bit ew = x_walk.exists(cyc);
    bit ea = x_al.exists(cyc);
    chk(req_ready == (m_cnt < MAXO), "R1 ready", req_ready, m_cnt < MAXO);
    chk(refused_cnt == REF_W'(m_ref), "R1 refused", refused_cnt, m_ref);
    chk(rsp_valid == er, "R3 R6 rsp_valid", rsp_valid, er);
    if (er && rsp_valid) begin
      chk(rsp_paddr == x_pa[cyc], "R10 paddr", rsp_paddr, x_pa[cyc]);
      chk(rsp_fault == x_f[cyc], "R8 fault", rsp_fault, x_f[cyc]);
      chk(rsp_code == x_c[cyc], "R8 code", rsp_code, x_c[cyc]);
      chk(rsp_uc == x_u[cyc], "R9 uc", rsp_uc, x_u[cyc]);
    end
    chk(walk_valid == ew, "R5 walk_valid", walk_valid, ew);
    if (ew && walk_valid) chk(walk_vpn == x_walk[cyc], "R5 walk_vpn", walk_vpn, x_walk[cyc]);
    chk(dn_valid == m_dn_v, "R4 dn_valid", dn_valid, m_dn_v);
    if (m_dn_v && dn_valid) chk(dn_vpn == m_dn_vpn, "R4 dn_vpn", dn_vpn, m_dn_vpn);
    chk(alloc_valid == ea, "R7 alloc_valid", alloc_valid, ea);
    if (ea && alloc_valid)
      chk({alloc_vpn, alloc_ppn} == x_al[cyc], "R7 alloc data", {alloc_vpn, alloc_ppn}, x_al[cyc]);
    chk(retry == (x_r.exists(cyc) ? {NUP{1'b1}} : '0), "R11 retry", retry, x_r.exists(cyc));
  endtask

  task automatic step();
    int e = cyc + 1;
    logic [VW-1:0] v = req_vaddr[VA_W-1:PS];
    m_acc = req_valid && (m_cnt < MAXO);
    if (req_valid && !m_acc) m_ref++;
    if (x_pa.exists(e)) begin m_cnt--; x_r[e+1] = 1'b1; end
    if (m_acc) begin
      m_cnt++;
      m_mode[int'(v)] = req_mode;
      m_off[int'(v)]  = req_vaddr[PS-1:0];
      if (f_hit(v)) put_rsp(e+H+1, f_ppn(v), v[1], v[2], req_mode, req_vaddr[PS-1:0]);
      else if (lower_en) begin dq_v.push_back(v); dq_e.push_back(e+H); end
      else x_walk[e+H+M] = v;
    end
    if (ret_valid) begin
      if (alloc_en) x_al[e+1] = {ret_vpn, ret_ppn};
      put_rsp(e+2, ret_ppn, ret_wr, ret_uc, m_mode[int'(ret_vpn)], m_off[int'(ret_vpn)]);
    end
    if (m_dn_v && dn_ready) m_dn_v = 0;
    else if (!m_dn_v && dq_v.size() > 0 && dq_e[0] < e) begin
      m_dn_v = 1; m_dn_vpn = dq_v.pop_front(); void'(dq_e.pop_front());
    end
    @(posedge clk);
    cyc = e;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // R2: every page issued here is distinct from all others in flight
  task automatic issue(int v, logic [PS-1:0] o, logic [1:0] md);
    req_valid = 1'b1; req_vaddr = {VW'(v), o}; req_mode = md;
    do step(); while (!m_acc);
    req_valid = 1'b0;
  endtask

  task automatic give_ret(int v, logic [PPN_W-1:0] p, logic w, logic u);
    ret_valid = 1'b1; ret_vpn = VW'(v); ret_ppn = p; ret_wr = w; ret_uc = u;
    step();
    ret_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog cycle %0d actual hung expected done", cyc);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R12 reset state
    chk(req_ready == 1'b1, "R12 ready", req_ready, 1);
    chk(refused_cnt == '0, "R12 refused", refused_cnt, 0);
    chk(!rsp_valid && !dn_valid && !walk_valid && !alloc_valid && retry == '0,
        "R12 outputs idle", {rsp_valid, dn_valid, walk_valid, alloc_valid, retry}, 0);
    // R3 hits, R8 modes, R10 offsets
    issue(1, 12'h123, 2'd0);
    issue(2, 12'h7FF, 2'd1);
    issue(4, 12'h010, 2'd2);
    issue(5, 12'hABC, 2'd1);
    idle(6);
    // R1 fill with walks, R5, R7 with alloc_en
    alloc_en = 1'b1;
    issue(3, 12'h001, 2'd1);
    issue(6, 12'h002, 2'd0);
    issue(9, 12'h003, 2'd1);
    issue(12, 12'h004, 2'd2);
    req_valid = 1'b1; req_vaddr = {VW'(15), 12'h005}; req_mode = 2'd0;
    idle(3);
    req_valid = 1'b0;
    idle(8);
    give_ret(3, 20'hABCDE, 1'b0, 1'b1); idle(2);
    give_ret(6, 20'h00123, 1'b1, 1'b0); idle(2);
    give_ret(9, 20'h0F0F0, 1'b1, 1'b1); idle(2);
    give_ret(12, 20'h55555, 1'b0, 1'b0); idle(4);
    issue(15, 12'h005, 2'd0);
    idle(7);
    give_ret(15, 20'h13579, 1'b1, 1'b0); idle(4);
    // R7 alloc_en low offers no fill
    alloc_en = 1'b0;
    issue(18, 12'hFFF, 2'd1);
    idle(8);
    give_ret(18, 20'h24680, 1'b1, 1'b1); idle(4);
    // R4 lower path with back-pressure
    lower_en = 1'b1; idle(1);
    issue(21, 12'h321, 2'd0);
    idle(6);
    dn_ready = 1'b1; step(); dn_ready = 1'b0;
    idle(2);
    give_ret(21, 20'h11111, 1'b0, 1'b1); idle(4);
    dn_ready = 1'b1;
    issue(24, 12'h444, 2'd1);
    issue(27, 12'h555, 2'd2);
    idle(6);
    give_ret(24, 20'h22222, 1'b0, 1'b0); idle(2);
    give_ret(27, 20'h33333, 1'b1, 1'b1); idle(4);
    finish_run();
  end
endmodule